// File: doc/BRIEF.md
# Leakage-Based Body-Bias Calibration Controller

This controller runs one calibration of a memory array's body bias. An external analog leakage monitor and two comparators do the measuring. Normally the array supply bypasses the monitor. When a calibration is requested, the controller opens that bypass so the array's total leakage current flows through the monitor.

The controller then waits a programmable number of settle cycles and samples the two comparator results through two-flop synchronizers. Each comparator reports whether the monitor voltage is above one of two references, a lower one and an upper one. The pair places the die in one of three process corners:

- Low leakage means a slow, high-threshold die, and the controller picks forward bias.
- High leakage means a fast, leaky die, and it picks reverse bias.
- Anything in between gets zero bias.

The chosen level is held on a registered 2-bit select until the next calibration. The bypass closes again and a one-cycle done pulse marks the end of the run. A comparator pair that cannot occur, above the upper reference but not above the lower one, leaves the bias unchanged and raises a sticky error flag.

Top module: `bias_cal_ctrl`

## Requirements
- R1: After a synchronous active-low reset, bias_sel is 2'b00 (zero bias), and bypass_open, cal_done and cal_err are all 0.
- R2: A cal_req seen high at a clock edge while no calibration runs sets bypass_open to 1 from that edge on.
- R3: bypass_open stays at 1 for exactly L+1 cycles, where L is settle_len, and a settle_len of 0 acts as 1. The comparators are taken as they were at the edge two cycles before the edge that clears bypass_open.
- R4: The sampled pair cmp_above_hi=0, cmp_above_lo=0 (leakage below the lower reference) sets bias_sel to 2'b01, forward bias.
- R5: The sampled pair cmp_above_hi=0, cmp_above_lo=1 (leakage between the references) sets bias_sel to 2'b00, zero bias.
- R6: The sampled pair cmp_above_hi=1, cmp_above_lo=1 (leakage above the upper reference) sets bias_sel to 2'b10, reverse bias.
- R7: The sampled pair cmp_above_hi=1, cmp_above_lo=0 leaves bias_sel unchanged and sets cal_err. cal_err stays 1 until reset.
- R8: bias_sel never shows 2'b11, and it changes only on the edge where bypass_open returns to 0.
- R9: cal_done is 1 for exactly one cycle per calibration: the first cycle in which bypass_open is 0 again.
- R10: cal_req is ignored while bypass_open is 1. It neither restarts nor extends the running calibration.
- R11: Between calibrations, bias_sel does not follow changes on the comparator inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cal_req | input | 1 | Start a calibration (accepted only when idle) |
| settle_len | input | SETTLE_W (8) | Settle cycles before sampling; 64 is the usual setting |
| cmp_above_lo | input | 1 | Monitor output above the lower reference (asynchronous) |
| cmp_above_hi | input | 1 | Monitor output above the upper reference (asynchronous) |
| bypass_open | output | 1 | 1 routes array supply through the leakage monitor |
| bias_sel | output | 2 | 00 zero, 01 forward, 10 reverse body bias |
| cal_done | output | 1 | One-cycle pulse when the bypass closes |
| cal_err | output | 1 | Sticky flag for an impossible comparator pair |

## Verification
A sequencer stuck or off by one shows up first on bypass_open. Its high time departs from settle_len+1 within the same calibration, and cal_done moves with it in the very cycle the bypass falls. A wrong synchronizer depth or a mis-decoded region shows on bias_sel in the cycle after the closing edge, as a code that disagrees with the pair held at the comparators. A lost sticky bit or a bias that drifts while idle is caught on the next cycle that is compared.

// File: rtl/bias_cal_pkg.sv
// Shared types for the body-bias calibration controller.
// Assumes the bias code values are decoded by the bias generators downstream.
package bias_cal_pkg;

    // Bias select code driven to the bias generators
    typedef enum logic [1:0] {
        BIAS_ZERO = 2'b00,
        BIAS_FWD  = 2'b01,
        BIAS_REV  = 2'b10
    } bias_code_t;

    // Controller sequence
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SETTLE = 2'b01,
        ST_SAMPLE = 2'b10
    } cal_state_t;

endpackage

// File: rtl/bias_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes each input bit is an independent level with no cross-bit coherency need.
module bias_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic meta_q;
            logic stab_q;
            // two-stage capture of bit b
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= d[b];
                    stab_q <= meta_q;
                end
            end
            assign q[b] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/bias_settle_timer.sv
// Settle-cycle counter: counts while run is high and flags the last settle cycle.
// Assumes len is held stable during a calibration; a len of 0 behaves like 1.
module bias_settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [SETTLE_W-1:0] len,
    output logic                last
);
    localparam int CW = SETTLE_W + 1;

    logic [SETTLE_W-1:0] cnt_q;
    logic [CW-1:0]       cnt_nxt;

    assign cnt_nxt = CW'(cnt_q) + CW'(1);
    assign last    = run && (cnt_nxt >= CW'(len));

    // count settle cycles, clear when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_nxt[SETTLE_W-1:0];
    end
endmodule

// File: rtl/bias_region_decode.sv
// Maps the synchronized comparator pair to a bias code.
// Assumes lower reference < upper reference, so above-upper implies above-lower.
module bias_region_decode
    import bias_cal_pkg::*;
(
    input  logic       above_lo,
    input  logic       above_hi,
    output bias_code_t code,
    output logic       legal
);
    // region to code lookup
    always_comb begin
        legal = 1'b1;
        code  = BIAS_ZERO;
        unique case ({above_hi, above_lo})
            2'b00: code = BIAS_FWD;
            2'b01: code = BIAS_ZERO;
            2'b11: code = BIAS_REV;
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/bias_cal_ctrl.sv
// Body-bias calibration controller top: opens the monitor bypass on request,
// waits settle_len cycles, samples synchronized comparators, latches a bias code,
// closes the bypass and pulses done.
// Assumes comparator outputs are stable for the last settle cycles.
module bias_cal_ctrl
    import bias_cal_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cal_req,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                cmp_above_lo,
    input  logic                cmp_above_hi,
    output logic                bypass_open,
    output logic [1:0]          bias_sel,
    output logic                cal_done,
    output logic                cal_err
);
    cal_state_t state_q;
    bias_code_t bias_q;
    bias_code_t dec_code;
    logic [1:0] cmp_sync;
    logic       dec_legal;
    logic       settle_last;
    logic       byp_q;
    logic       done_q;
    logic       err_q;

    bias_sync #(.W(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp_above_hi, cmp_above_lo}),
        .q     (cmp_sync)
    );

    bias_settle_timer #(.SETTLE_W(SETTLE_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SETTLE),
        .len   (settle_len),
        .last  (settle_last)
    );

    bias_region_decode i_dec (
        .above_lo (cmp_sync[0]),
        .above_hi (cmp_sync[1]),
        .code     (dec_code),
        .legal    (dec_legal)
    );

    // calibration sequence, bypass control, bias latch and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bias_q  <= BIAS_ZERO;
            byp_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cal_req) begin
                        state_q <= ST_SETTLE;
                        byp_q   <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (settle_last) state_q <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    if (dec_legal) bias_q <= dec_code;
                    else           err_q  <= 1'b1;
                    byp_q   <= 1'b0;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bypass_open = byp_q;
    assign bias_sel    = bias_q;
    assign cal_done    = done_q;
    assign cal_err     = err_q;

    // R8
    bias_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_sel != 2'b11);

    // R8
    bias_change_only_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bias_sel) |-> (cal_done && !bypass_open));

    // R9
    done_on_bypass_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (!bypass_open && $past(bypass_open)));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |=> cal_err);

    // R2
    bypass_open_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_open) |-> $past(cal_req));
endmodule

// File: tb/test_bias_cal_ctrl.sv
// Bench: behavioural reference model updated each rising edge, compared at falling edges.
module test_bias_cal_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_req = 1'b0;
    logic [7:0] settle_len = 8'd64;
    logic       cmp_above_lo = 1'b0;
    logic       cmp_above_hi = 1'b0;
    logic       bypass_open;
    logic [1:0] bias_sel;
    logic       cal_done;
    logic       cal_err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit started = 0;

    // reference model state
    int m_state = 0, m_cnt = 0, m_bias = 0;
    bit m_byp = 0, m_done = 0, m_err = 0, m_h1 = 0, m_h2 = 0, m_l1 = 0, m_l2 = 0;

    always #2 clk = ~clk; // 250 MHz

    bias_cal_ctrl #(.SETTLE_W(8)) i_bias_cal_ctrl (
        .clk, .rst_n, .cal_req, .settle_len, .cmp_above_lo, .cmp_above_hi,
        .bypass_open, .bias_sel, .cal_done, .cal_err
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // reference model
    always @(posedge clk) begin
        bit sh, sl;
        int len;
        cycles++;
        started = 1;
        sh = m_h2; sl = m_l2;
        len = (settle_len == 0) ? 1 : int'(settle_len);
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_bias = 0; m_byp = 0; m_done = 0; m_err = 0;
            m_h1 = 0; m_h2 = 0; m_l1 = 0; m_l2 = 0;
        end else begin
            m_h2 = m_h1; m_h1 = cmp_above_hi;
            m_l2 = m_l1; m_l1 = cmp_above_lo;
            m_done = 0;
            if (m_state == 0) begin
                if (cal_req) begin m_state = 1; m_cnt = 0; m_byp = 1; end
            end else if (m_state == 1) begin
                m_cnt++;
                if (m_cnt >= len) m_state = 2;
            end else begin
                if (!sh && !sl)      m_bias = 1;
                else if (!sh && sl)  m_bias = 0;
                else if (sh && sl)   m_bias = 2;
                else                 m_err = 1;
                m_byp = 0; m_done = 1; m_state = 0;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            check(m_bias == 1 ? "R4" : (m_bias == 2 ? "R6" : "R5"), int'(bias_sel), m_bias);
            check("R3", int'(bypass_open), int'(m_byp));
            check("R9", int'(cal_done), int'(m_done));
            check("R7", int'(cal_err), int'(m_err));
        end
    end

    // run one calibration; comparators held stable throughout
    task automatic calibrate(input bit hi, input bit lo, input int len, input bit poke);
        int open_cycles = 0;
        int dones = 0;
        @(negedge clk);
        cmp_above_hi = hi; cmp_above_lo = lo; settle_len = 8'(len);
        repeat (3) @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        check("R2", int'(bypass_open), 1);
        while (bypass_open) begin
            open_cycles++;
            if (poke && open_cycles == 2) cal_req = 1'b1;
            if (poke && open_cycles == 3) cal_req = 1'b0;
            @(negedge clk);
            if (cal_done) dones++;
            if (open_cycles > 400) break;
        end
        cal_req = 1'b0;
        check("R3", open_cycles, ((len == 0) ? 1 : len) + 1);
        check("R9", dones, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            check("R10", int'(bypass_open), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(bias_sel), 0);
        check("R1", int'(bypass_open), 0);
        check("R1", int'(cal_done), 0);
        check("R1", int'(cal_err), 0);
        rst_n = 1'b1;
        calibrate(1'b0, 1'b0, 64, 1'b0);
        check("R4", int'(bias_sel), 1);
        calibrate(1'b1, 1'b1, 64, 1'b0);
        check("R6", int'(bias_sel), 2);
        calibrate(1'b0, 1'b1, 64, 1'b0);
        check("R5", int'(bias_sel), 0);
        calibrate(1'b1, 1'b1, 5, 1'b1);
        check("R10", int'(bias_sel), 2);
        calibrate(1'b1, 1'b0, 3, 1'b0);
        check("R7", int'(bias_sel), 2);
        check("R7", int'(cal_err), 1);
        calibrate(1'b0, 1'b0, 0, 1'b0);
        check("R4", int'(bias_sel), 1);
        check("R7", int'(cal_err), 1);
        calibrate(1'b0, 1'b1, 1, 1'b0);
        check("R5", int'(bias_sel), 0);
        // R11: comparators move while idle
        for (int k = 0; k < 20; k++) begin
            cmp_above_hi = k[0]; cmp_above_lo = k[1];
            @(negedge clk);
            check("R11", int'(bias_sel), 0);
        end
        calibrate(1'b1, 1'b1, 2, 1'b0);
        check("R6", int'(bias_sel), 2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", int'(bias_sel), 0);
        check("R1", int'(cal_err), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule